// File: doc/BRIEF.md
# High-Speed Receive Deserializer

This block sits between a clock-and-data-recovery front end and a device controller. The front end delivers one recovered line level per clock together with a qualifier that says the bus carries valid signalling. The block undoes the NRZI line coding and hunts for the end of the start-of-packet pattern. It then removes the bits the transmitter inserted to bound runs of ones, collects the remaining bits into bytes, and recognises the end-of-packet pattern. The controller sees only payload bytes: a packet-active level, a one-clock byte strobe with its byte, and an error pulse that is timed like the data.

Separately, the block reports the full-speed line state from the two data-line receivers as a 2-bit code. While the transceiver runs, this code passes through a short synchronizer. While it is suspended, the code follows the pins directly.

Top module: `utmi_rx_deser`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rxActive`, `rxValid` and `rxError` are 0 and `lineState` reads 00.
- R2: A bit decodes as 1 when the sampled level equals the previous sampled level, and as 0 when it differs. The first bit after `lineValid` rises is compared against level 1 (idle J).
- R3: `rxActive` rises in the cycle after the edge that samples a decoded 1 that follows at least `SyncZeros` consecutive decoded zeros (default 5), all with `lineValid` high. A decoded 1 after fewer zeros restarts the hunt.
- R4: Bytes are assembled LSB first. `rxValid` is high for exactly one clock per byte and only while `rxActive` is high. `rxData` holds its value between bytes.
- R5: A decoded 0 that follows `StuffRun` consecutive decoded ones (default 6) is discarded. The run count is cleared when the packet starts.
- R6: Start and end pattern bits never reach `rxData`. A well-formed packet delivers exactly its payload bytes, in order.
- R7: An end of packet is a decoded 1 that arrives when the run count is already full, followed at the next edge by `lineValid` low. If exactly `EopTail` (default 7) bits are pending in the assembler at that point, the end is clean: `rxActive` stays high for one more cycle with `rxError` 0, and then falls.
- R8: If any other number of bits is pending at end of packet, `rxError` pulses in that final active cycle.
- R9: If `lineValid` is still high after a stuffing violation, `rxError` pulses in the next cycle. No bytes are delivered after that point. `rxActive` stays high until the edge that samples `lineValid` low, and is 0 in the cycle after that edge.
- R10: If `lineValid` falls during a packet with no violation pending, `rxError` pulses in a final active cycle, after which `rxActive` falls.
- R11: With `suspendN` high, `lineState` equals {`lineDm`,`lineDp`} as sampled two clock edges earlier (bit 0 follows DP, bit 1 follows DM; 00 SE0, 01 J, 10 K, 11 SE1).
- R12: With `suspendN` low, `lineState` equals {`lineDm`,`lineDp`} in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, one recovered bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| lineValid | input | 1 | Front end reports valid signalling on the bus |
| rxLevel | input | 1 | Recovered line level for this cycle |
| suspendN | input | 1 | Low while the transceiver is suspended |
| lineDp | input | 1 | Single-ended DP receiver |
| lineDm | input | 1 | Single-ended DM receiver |
| rxActive | output | 1 | Packet in progress |
| rxValid | output | 1 | One-clock strobe: `rxData` holds a new byte |
| rxError | output | 1 | Receive error pulse, timed like data |
| rxData | output | ByteW | Received payload byte |
| lineState | output | 2 | Line state code {DM, DP} |

## Verification
On every cycle the assertions check the framing relations between the strobes. A byte strobe or an error pulse must fall inside an active packet, a byte strobe lasts one clock, and the data holds between bytes. A packet cannot start without valid signalling, and no byte follows an error. They also check the line-state path in both the synchronized and the suspended mode. Only the bench scenarios show that decoding, sync hunting, unstuffing and the choice between a clean end and an error produce the right bytes and pulses. These scenarios are: minimal and short sync, long runs of ones, a partial final byte, a stuffing violation mid-packet, and loss of signal.

// File: rtl/utmi_rx_pkg.sv
package utmi_rx_pkg;

  typedef enum logic [2:0] {
    StIdle,
    StActive,
    StViol,
    StDrain,
    StEnding
  } rxState_t;

  // control -> datapath
  typedef struct packed {
    logic huntEn;
    logic dataEn;
    logic dropEn;
    logic clearPkt;
    logic errPulse;
  } rxStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic decBit;
    logic syncHit;
    logic onesFull;
    logic tailClean;
  } rxStatus_t;

endpackage

// File: rtl/utmi_rx_datapath.sv
module utmi_rx_datapath
  import utmi_rx_pkg::*;
#(
  parameter int ByteW      = 8,
  parameter int SyncZeros  = 5,
  parameter int StuffRun   = 6,
  parameter int EopTail    = 7,
  parameter int SyncStages = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lineValid,
  input  logic             rxLevel,
  input  logic             suspendN,
  input  logic             lineDp,
  input  logic             lineDm,
  input  rxStrobe_t        strobe,
  output rxStatus_t        status,
  output logic             rxValid,
  output logic             rxError,
  output logic [ByteW-1:0] rxData,
  output logic [1:0]       lineState
);

  localparam int CntW  = $clog2(ByteW);
  localparam int ZeroW = $clog2(SyncZeros + 1);
  localparam int OnesW = $clog2(StuffRun + 1);

  logic             prevLevel;
  logic             decBit;
  logic [ZeroW-1:0] zeroCnt;
  logic [OnesW-1:0] onesCnt;
  logic [CntW-1:0]  bitCnt;
  logic [ByteW-2:0] shiftReg;
  logic [ByteW-1:0] shiftNext;
  logic             byteLast;

  // NRZI decode against the previous level; idle counts as J
  assign decBit = lineValid && (rxLevel == prevLevel);

  always_ff @(posedge clk) begin
    if (rst) prevLevel <= 1'b1;
    else     prevLevel <= lineValid ? rxLevel : 1'b1;
  end

  // start-of-packet hunt: saturating zero counter
  always_ff @(posedge clk) begin
    if (rst || !strobe.huntEn || decBit) begin
      zeroCnt <= '0;
    end else if (zeroCnt != ZeroW'(SyncZeros)) begin
      zeroCnt <= zeroCnt + 1'b1;
    end
  end

  // run-of-ones tracker for unstuffing
  always_ff @(posedge clk) begin
    if (rst || strobe.clearPkt || strobe.dropEn) begin
      onesCnt <= '0;
    end else if (strobe.dataEn) begin
      onesCnt <= decBit ? onesCnt + 1'b1 : '0;
    end
  end

  // byte assembler, LSB first
  assign shiftNext = {decBit, shiftReg};
  assign byteLast  = (bitCnt == CntW'(ByteW - 1));

  always_ff @(posedge clk) begin
    if (rst || strobe.clearPkt) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (strobe.dataEn) begin
      shiftReg <= shiftNext[ByteW-1:1];
      bitCnt   <= byteLast ? '0 : bitCnt + 1'b1;
    end
  end

  // holding register and strobes toward the controller
  always_ff @(posedge clk) begin
    if (rst) begin
      rxValid <= 1'b0;
      rxError <= 1'b0;
      rxData  <= '0;
    end else begin
      rxValid <= strobe.dataEn && byteLast;
      rxError <= strobe.errPulse;
      if (strobe.dataEn && byteLast) rxData <= shiftNext;
    end
  end

  assign status.decBit    = decBit;
  assign status.syncHit   = decBit && (zeroCnt == ZeroW'(SyncZeros));
  assign status.onesFull  = (onesCnt == OnesW'(StuffRun));
  assign status.tailClean = (bitCnt == CntW'(EopTail));

  // line state synchronizer chain
  logic [SyncStages-1:0][1:0] lsPipe;

  always_ff @(posedge clk) begin
    if (rst) lsPipe[0] <= 2'b00;
    else     lsPipe[0] <= {lineDm, lineDp};
  end

  for (genvar s = 1; s < SyncStages; s++) begin : g_lsStage
    always_ff @(posedge clk) begin
      if (rst) lsPipe[s] <= 2'b00;
      else     lsPipe[s] <= lsPipe[s-1];
    end
  end

  assign lineState = suspendN ? lsPipe[SyncStages-1] : {lineDm, lineDp};

endmodule

// File: rtl/utmi_rx_ctrl.sv
module utmi_rx_ctrl
  import utmi_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lineValid,
  input  rxStatus_t status,
  output rxStrobe_t strobe,
  output logic      rxActive
);

  rxState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= StIdle;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      StIdle: begin
        strobe.huntEn = lineValid;
        if (status.syncHit) begin
          stateNext       = StActive;
          strobe.clearPkt = 1'b1;
        end
      end
      StActive: begin
        if (!lineValid) begin
          strobe.errPulse = 1'b1;
          stateNext       = StEnding;
        end else if (status.onesFull) begin
          if (status.decBit) stateNext     = StViol;
          else               strobe.dropEn = 1'b1;
        end else begin
          strobe.dataEn = 1'b1;
        end
      end
      StViol: begin
        if (!lineValid) begin
          strobe.errPulse = !status.tailClean;
          stateNext       = StEnding;
        end else begin
          strobe.errPulse = 1'b1;
          stateNext       = StDrain;
        end
      end
      StDrain: begin
        if (!lineValid) stateNext = StIdle;
      end
      StEnding: begin
        stateNext = StIdle;
      end
      default: stateNext = StIdle;
    endcase
  end

  assign rxActive = (state != StIdle);

endmodule

// File: rtl/utmi_rx_deser.sv
module utmi_rx_deser
  import utmi_rx_pkg::*;
#(
  parameter int ByteW      = 8,
  parameter int SyncZeros  = 5,
  parameter int StuffRun   = 6,
  parameter int EopTail    = 7,
  parameter int SyncStages = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lineValid,
  input  logic             rxLevel,
  input  logic             suspendN,
  input  logic             lineDp,
  input  logic             lineDm,
  output logic             rxActive,
  output logic             rxValid,
  output logic             rxError,
  output logic [ByteW-1:0] rxData,
  output logic [1:0]       lineState
);

  rxStrobe_t strobe;
  rxStatus_t status;

  utmi_rx_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .lineValid(lineValid),
    .status   (status),
    .strobe   (strobe),
    .rxActive (rxActive)
  );

  utmi_rx_datapath #(
    .ByteW     (ByteW),
    .SyncZeros (SyncZeros),
    .StuffRun  (StuffRun),
    .EopTail   (EopTail),
    .SyncStages(SyncStages)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .lineValid(lineValid),
    .rxLevel  (rxLevel),
    .suspendN (suspendN),
    .lineDp   (lineDp),
    .lineDm   (lineDm),
    .strobe   (strobe),
    .status   (status),
    .rxValid  (rxValid),
    .rxError  (rxError),
    .rxData   (rxData),
    .lineState(lineState)
  );

endmodule

// File: rtl/utmi_rx_deser_chk.sv
module utmi_rx_deser_chk #(
  parameter int ByteW      = 8,
  parameter int SyncStages = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             lineValid,
  input logic             suspendN,
  input logic             lineDp,
  input logic             lineDm,
  input logic             rxActive,
  input logic             rxValid,
  input logic             rxError,
  input logic [ByteW-1:0] rxData,
  input logic [1:0]       lineState
);

  logic [1:0] runCyc;

  always_ff @(posedge clk) begin
    if (rst)                 runCyc <= '0;
    else if (runCyc != 2'd3) runCyc <= runCyc + 1'b1;
  end

  // R4
  valid_in_pkt_chk: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> rxActive);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (runCyc != 2'd0 && !rxValid) |-> $stable(rxData));

  // R8
  err_in_pkt_chk: assert property (@(posedge clk) disable iff (rst)
    rxError |-> rxActive);

  // R9
  quiet_after_err_chk: assert property (@(posedge clk) disable iff (rst)
    rxError |=> !rxValid);

  // R3
  start_needs_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (runCyc != 2'd0 && $rose(rxActive)) |-> $past(lineValid));

  // R12
  ls_suspend_chk: assert property (@(posedge clk) disable iff (rst)
    !suspendN |-> (lineState == {lineDm, lineDp}));

  if (SyncStages == 2) begin : g_syncChk
    // R11
    ls_sync_chk: assert property (@(posedge clk) disable iff (rst)
      (runCyc >= 2'd2 && suspendN) |-> (lineState == $past({lineDm, lineDp}, 2)));
  end

endmodule

bind utmi_rx_deser utmi_rx_deser_chk #(.ByteW(ByteW), .SyncStages(SyncStages)) u_chk (.*);

// File: tb/utmi_rx_deser_tb.sv
module utmi_rx_deser_tb;

  localparam int SZ = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineValid = 1'b0;
  logic rxLevel = 1'b1;
  logic suspendN = 1'b1;
  logic lineDp = 1'b1;
  logic lineDm = 1'b0;
  logic rxActive, rxValid, rxError;
  logic [7:0] rxData;
  logic [1:0] lineState;

  always #4 clk = ~clk;

  utmi_rx_deser u_dut (
    .clk(clk), .rst(rst), .lineValid(lineValid), .rxLevel(rxLevel),
    .suspendN(suspendN), .lineDp(lineDp), .lineDm(lineDm),
    .rxActive(rxActive), .rxValid(rxValid), .rxError(rxError),
    .rxData(rxData), .lineState(lineState)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int cyc = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on each rising edge
  int mSt = 0; // 0 idle,1 active,2 violation seen,3 draining,4 ending
  int mPrev = 1, mZeros = 0, mOnes = 0, mBits = 0, mShift = 0;
  int mValid = 0, mErr = 0, mData = 0;
  int h0 = 0, h1 = 0;

  always @(posedge clk) begin
    int dec;
    cyc++;
    if (rst) begin
      mSt = 0; mPrev = 1; mZeros = 0; mOnes = 0; mBits = 0; mShift = 0;
      mValid = 0; mErr = 0; mData = 0; h0 = 0; h1 = 0;
    end else begin
      h1 = h0;
      h0 = {lineDm, lineDp};
      dec = (lineValid && (rxLevel == mPrev[0])) ? 1 : 0;
      mPrev = lineValid ? rxLevel : 1;
      mValid = 0;
      mErr = 0;
      case (mSt)
        0: begin
          if (!lineValid) mZeros = 0;
          else if (dec == 0) mZeros++;
          else if (mZeros >= SZ) begin
            mSt = 1; mZeros = 0; mOnes = 0; mBits = 0; mShift = 0;
          end else mZeros = 0;
        end
        1: begin
          if (!lineValid) begin mSt = 4; mErr = 1; end
          else if (mOnes == 6) begin
            if (dec == 1) mSt = 2; else mOnes = 0;
          end else begin
            mShift = mShift | (dec << mBits);
            mBits++;
            mOnes = dec ? mOnes + 1 : 0;
            if (mBits == 8) begin
              mValid = 1; mData = mShift; mShift = 0; mBits = 0;
            end
          end
        end
        2: begin
          if (!lineValid) begin mSt = 4; mErr = (mBits != 7) ? 1 : 0; end
          else begin mSt = 3; mErr = 1; end
        end
        3: if (!lineValid) mSt = 0;
        default: mSt = 0;
      endcase
    end
  end

  byte got[$];
  bit sawErr = 0, sawAct = 0;

  // compare on every falling edge, before inputs change
  always @(negedge clk) begin
    if (!done) begin
      chk(rxActive == (mSt != 0), "R3 rxActive", rxActive, mSt != 0);
      chk(rxValid == mValid[0], "R4 rxValid", rxValid, mValid);
      if (mValid != 0) chk(rxData == mData[7:0], "R4 rxData", rxData, mData);
      chk(rxError == mErr[0], "R8 rxError", rxError, mErr);
      if (suspendN) chk(lineState == h1[1:0], "R11 lineState", lineState, h1);
      else chk(lineState == {lineDm, lineDp}, "R12 lineState", lineState, {lineDm, lineDp});
      if (rxValid) got.push_back(rxData);
      if (rxError) sawErr = 1;
      if (rxActive) sawAct = 1;
    end
  end

  int lsPat = 0;
  task automatic tick(bit lv, bit lvl);
    @(negedge clk);
    #1;
    lineValid = lv;
    rxLevel = lv ? lvl : 1'b1;
    lsPat++;
    lineDp = lsPat[0];
    lineDm = lsPat[2];
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1);
  endtask

  // mode: 0 clean, 1 partial tail, 2 violation after byte errIdx, 3 lose signal
  task automatic sendPkt(byte d[$], int zeros, int mode, int errIdx);
    bit q[$];
    int ones = 0;
    bit lvl = 1'b1;
    for (int i = 0; i < zeros; i++) q.push_back(1'b0);
    q.push_back(1'b1);
    for (int k = 0; k < d.size(); k++) begin
      for (int b = 0; b < 8; b++) begin
        q.push_back(d[k][b]);
        ones = d[k][b] ? ones + 1 : 0;
        if (ones == 6) begin q.push_back(1'b0); ones = 0; end
      end
      if (mode == 2 && k == errIdx) begin
        for (int i = 0; i < 7; i++) q.push_back(1'b1);
        for (int i = 0; i < 10; i++) q.push_back(i[0]);
      end
    end
    if (mode == 1) begin
      q.push_back(1'b1); q.push_back(1'b0); q.push_back(1'b1);
    end
    if (mode != 3) begin
      q.push_back(1'b0);
      for (int i = 0; i < 7; i++) q.push_back(1'b1);
    end
    got.delete();
    sawErr = 0;
    sawAct = 0;
    foreach (q[i]) begin
      if (q[i] == 1'b0) lvl = ~lvl;
      tick(1'b1, lvl);
    end
    idle(4);
  endtask

  initial begin
    byte d[$];
    idle(3);
    chk(rxActive == 0, "R1 rxActive in reset", rxActive, 0);
    chk(rxValid == 0, "R1 rxValid in reset", rxValid, 0);
    chk(rxError == 0, "R1 rxError in reset", rxError, 0);
    chk(lineState == 2'b00, "R1 lineState in reset", lineState, 0);
    @(negedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk(rxActive == 0 && rxValid == 0 && rxError == 0, "R1 after reset", {rxActive, rxValid, rxError}, 0);
    idle(4);

    // R2 R6 R7: clean packet, long sync
    d = '{8'hA5, 8'h3C, 8'h81, 8'h00};
    sendPkt(d, 12, 0, 0);
    chk(got.size() == 4, "R6 byte count", got.size(), 4);
    for (int i = 0; i < 4; i++) if (i < got.size()) chk(got[i] == d[i], "R2 R6 payload", got[i], d[i]);
    chk(sawErr == 0, "R7 clean end no error", sawErr, 0);

    // R5: long runs of ones needing stuffing
    d = '{8'hFF, 8'hFF, 8'h7E, 8'hFC};
    sendPkt(d, SZ, 0, 0);
    chk(got.size() == 4, "R5 byte count", got.size(), 4);
    for (int i = 0; i < 4; i++) if (i < got.size()) chk(got[i] == d[i], "R5 unstuffed payload", got[i], d[i]);
    chk(sawErr == 0, "R5 no error", sawErr, 0);

    // R3: one zero short of sync, payload without five zeros
    d = '{8'hFF, 8'hFF};
    sendPkt(d, SZ - 1, 0, 0);
    chk(sawAct == 0, "R3 short sync ignored", sawAct, 0);
    chk(got.size() == 0, "R3 no bytes", got.size(), 0);

    // R8: partial final byte
    d = '{8'h12, 8'h34};
    sendPkt(d, 8, 1, 0);
    chk(sawErr == 1, "R8 partial tail error", sawErr, 1);

    // R9: violation mid packet
    d = '{8'h55, 8'h0F, 8'hAA};
    sendPkt(d, 8, 2, 0);
    chk(sawErr == 1, "R9 violation error", sawErr, 1);
    chk(got.size() == 1, "R9 bytes stop", got.size(), 1);
    chk(rxActive == 0, "R9 active dropped", rxActive, 0);

    // R10: signal lost mid packet
    d = '{8'hC3, 8'h5A};
    sendPkt(d, 8, 3, 0);
    chk(sawErr == 1, "R10 loss error", sawErr, 1);
    chk(got.size() == 2, "R10 bytes before loss", got.size(), 2);

    // R12: suspended line state
    @(negedge clk); #1; suspendN = 1'b0;
    idle(6);
    @(negedge clk); #1; suspendN = 1'b1;
    idle(6);

    // back-to-back clean packet after errors
    d = '{8'h01, 8'h80};
    sendPkt(d, SZ, 0, 0);
    chk(got.size() == 2 && sawErr == 0, "R7 recovery packet", got.size(), 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule